// File: doc/BRIEF.md
# SRAM Array Access Phase Sequencer

This block is a cycle-level behavioural controller for a synchronous single-port SRAM array. It turns one request into a short, fixed sequence of internal phases and exposes each phase as a control signal that can be observed. The phases are bitline precharge, wordline pulse, and then either sense-amplifier firing for a read or bitline drive for a write. The storage itself is a register array made of physical rows. Each row is `DATA_W * COL_MUX` bits wide. Each logical word is spread across that row with column interleaving: bit `i` of column `c` sits at physical bit `i*COL_MUX + c`. Through this interleaving, `COL_MUX` columns share one sense path for each data bit.

A client presents a request with `ce` high while `ready` is high. The request is captured at that clock edge and the sequence runs on its own after that. A read ends with the selected word loaded into an output set/reset-style holding register. That register keeps its value until the next read completes. A write applies a per-bit mask: bits whose mask is 0 are not driven, so they behave as a read and keep their stored value. While a sequence is running, `ready` is low and any request is dropped.

Top module: `sram_phase_seq`

## Requirements
- R1: After synchronous reset, `ready` is 1, `pre_en`, `wl_en`, `sae_en` and `wdrv_en` are 0, and `rdata` is 0.
- R2: A request with `ce`=1 while `ready`=1 is accepted at that clock edge. In the next cycle `ready` is 0 and only `pre_en` is asserted.
- R3: A read runs three phases of one cycle each, in this order: precharge (`pre_en`), wordline (`wl_en`), sense (`sae_en`). `ready` returns in the cycle after the sense phase, with `rdata` already holding the addressed word.
- R4: A write runs two phases of one cycle each: precharge, then wordline with `wdrv_en` asserted together with it. `ready` returns in the following cycle, with the array already updated.
- R5: In every cycle at most one of `pre_en`, `wl_en`, `sae_en` is 1, and `wdrv_en` is 1 only while `wl_en` is 1.
- R6: The low `log2(COL_MUX)` address bits select the column and the remaining high bits select the row. Each of the `ROWS*COL_MUX` addresses holds an independent word.
- R7: On a write, data bit `i` is stored when `wmask[i]`=1 and keeps its previous value when `wmask[i]`=0. An all-zero mask changes nothing.
- R8: `rdata` changes only at the end of a read's sense phase. It is unchanged during write sequences, during idle cycles, and during the earlier phases of a read.
- R9: A request presented while `ready`=0 is ignored. It does not alter the array, the running sequence or `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Request strobe, taken when `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address: high bits select the row, low bits select the column |
| wmask | input | DATA_W | Per-bit write enable |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Held read data |
| ready | output | 1 | Idle and able to take a request |
| pre_en | output | 1 | Precharge phase active |
| wl_en | output | 1 | Wordline phase active |
| sae_en | output | 1 | Sense phase active |
| wdrv_en | output | 1 | Bitline write drive active |

## Verification
The case hardest to reach from the ports is a request that arrives in the middle of a sequence. It has to be shown harmless to three things: the phase order, the stored words and the held read data. The stimulus keeps `ce` high through the busy phases of chosen accesses. In those requests it flips the operation, targets the neighbouring column and inverts the data. A later read of that neighbour then shows that nothing was stored. Random reads and masked writes with random masks run against a bench memory model. They cover column interleaving within a shared row, and they confirm that unmasked bits keep their values.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_WL_RD = 3'd2,
    PH_WL_WR = 3'd3,
    PH_SENSE = 3'd4
  } phase_t;
endpackage

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_write,
  output logic ready,
  output logic pre_en,
  output logic wl_en,
  output logic sae_en,
  output logic wdrv_en,
  output logic arr_rd,
  output logic arr_wr,
  output logic load_out
);
  phase_t ph_q, ph_d;
  logic   wr_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start) ph_d = PH_PRE;
      PH_PRE:   ph_d = wr_q ? PH_WL_WR : PH_WL_RD;
      PH_WL_RD: ph_d = PH_SENSE;
      PH_WL_WR: ph_d = PH_IDLE;
      PH_SENSE: ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_IDLE && start) wr_q <= is_write;
    end
  end

  assign ready    = (ph_q == PH_IDLE);
  assign pre_en   = (ph_q == PH_PRE);
  assign wl_en    = (ph_q == PH_WL_RD) || (ph_q == PH_WL_WR);
  assign wdrv_en  = (ph_q == PH_WL_WR);
  assign sae_en   = (ph_q == PH_SENSE);
  assign arr_rd   = (ph_q == PH_WL_RD);
  assign arr_wr   = (ph_q == PH_WL_WR);
  assign load_out = (ph_q == PH_SENSE);

  assert_phase_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pre_en, wl_en, sae_en}) && (!wdrv_en || wl_en));
  assert_accept_pre_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (pre_en && !ready));
  assert_pre_then_wl_R3: assert property (@(posedge clk) disable iff (rst)
    pre_en |=> wl_en);
  assert_sense_after_wl_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sae_en) |-> $past(wl_en && !wdrv_en));
  assert_write_ends_R4: assert property (@(posedge clk) disable iff (rst)
    wdrv_en |=> ready);
endmodule

// File: rtl/sram_bit_array.sv
module sram_bit_array #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 128,
  localparam int RB   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [RB-1:0]    row,
  input  logic [ROW_W-1:0] wr_bits,
  input  logic [ROW_W-1:0] wr_drive,
  output logic [ROW_W-1:0] rd_bits
);
  logic [ROW_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (wr_drive[b]) cells[row][b] <= wr_bits[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_bits <= cells[row];
  end
endmodule

// File: rtl/sram_col_latch.sv
module sram_col_latch #(
  parameter int DATA_W  = 32,
  parameter int COL_MUX = 4,
  localparam int CB     = $clog2(COL_MUX),
  localparam int ROW_W  = DATA_W * COL_MUX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CB-1:0]     col,
  input  logic [ROW_W-1:0]  row_bits,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] sensed;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      sensed[i] = row_bits[i*COL_MUX + int'(col)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= sensed;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dout));
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq #(
  parameter int DATA_W  = 32,
  parameter int COL_MUX = 4,
  parameter int ROWS    = 16,
  localparam int CB     = $clog2(COL_MUX),
  localparam int RB     = $clog2(ROWS),
  localparam int ADDR_W = RB + CB,
  localparam int ROW_W  = DATA_W * COL_MUX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              pre_en,
  output logic              wl_en,
  output logic              sae_en,
  output logic              wdrv_en
);
  logic              start, arr_rd, arr_wr, load_out;
  logic [RB-1:0]     row_q;
  logic [CB-1:0]     col_q;
  logic [DATA_W-1:0] mask_q, data_q;
  logic [ROW_W-1:0]  row_bits, row_drive, row_rd;

  assign start = ce && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else if (start) begin
      row_q  <= addr[ADDR_W-1:CB];
      col_q  <= addr[CB-1:0];
      mask_q <= wmask;
      data_q <= wdata;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    for (genvar c = 0; c < COL_MUX; c++) begin : g_col
      assign row_bits[i*COL_MUX + c]  = data_q[i];
      assign row_drive[i*COL_MUX + c] = mask_q[i] && (col_q == CB'(c));
    end
  end

  sram_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .is_write(we),
    .ready(ready), .pre_en(pre_en), .wl_en(wl_en), .sae_en(sae_en),
    .wdrv_en(wdrv_en), .arr_rd(arr_rd), .arr_wr(arr_wr), .load_out(load_out)
  );

  sram_bit_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rd_en(arr_rd), .wr_en(arr_wr), .row(row_q),
    .wr_bits(row_bits), .wr_drive(row_drive), .rd_bits(row_rd)
  );

  sram_col_latch #(.DATA_W(DATA_W), .COL_MUX(COL_MUX)) u_out (
    .clk(clk), .rst(rst), .load(load_out), .col(col_q),
    .row_bits(row_rd), .dout(rdata)
  );

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (!ready && ce) |=> $stable(row_q) && $stable(col_q) && $stable(data_q));
  assert_rdata_write_R8: assert property (@(posedge clk) disable iff (rst)
    wdrv_en |=> $stable(rdata));
endmodule

// File: tb/tb_sram_phase_seq.sv
module tb_sram_phase_seq;
  localparam int DATA_W  = 32;
  localparam int COL_MUX = 4;
  localparam int ROWS    = 16;
  localparam int WORDS   = ROWS * COL_MUX;
  localparam int AW      = $clog2(ROWS) + $clog2(COL_MUX);

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DATA_W-1:0] wmask = '0, wdata = '0, rdata;
  logic ready, pre_en, wl_en, sae_en, wdrv_en;

  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] model [WORDS];
  logic [DATA_W-1:0] last_rd = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_phase_seq #(.DATA_W(DATA_W), .COL_MUX(COL_MUX), .ROWS(ROWS)) dut (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr), .wmask(wmask),
    .wdata(wdata), .rdata(rdata), .ready(ready), .pre_en(pre_en),
    .wl_en(wl_en), .sae_en(sae_en), .wdrv_en(wdrv_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packed order: ready, pre, wl, sae, drv
  function automatic logic [4:0] ph_now();
    return {ready, pre_en, wl_en, sae_en, wdrv_en};
  endfunction

  // R5 checked in every cycle out of reset
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if ($countones({pre_en, wl_en, sae_en}) > 1 || (wdrv_en && !wl_en)) begin
        n_bad++;
        $display("FAIL R5 actual=%b expected=onehot0", {pre_en, wl_en, sae_en, wdrv_en});
      end
    end
  end

  task automatic do_op(input bit w, input logic [AW-1:0] a,
                       input logic [DATA_W-1:0] m, input logic [DATA_W-1:0] d,
                       input bit poke);
    logic [DATA_W-1:0] exp;
    @(negedge clk);
    ce = 1'b1; we = w; addr = a; wmask = m; wdata = d;
    @(negedge clk);
    chk("R2 precharge after accept", ph_now(), 5'b01000);
    if (poke) begin
      ce = 1'b1; we = ~w; addr = a ^ AW'(1); wmask = '1; wdata = ~d;
    end else ce = 1'b0;
    @(negedge clk);
    chk(w ? "R4 wordline+drive" : "R3 wordline", ph_now(), {4'b0010, w});
    chk("R8 rdata held", rdata, last_rd);
    if (w) begin
      @(negedge clk);
      ce = 1'b0;
      chk("R4 ready after write", ph_now(), 5'b10000);
      chk("R8 rdata unchanged by write", rdata, last_rd);
      model[a] = (model[a] & ~m) | (d & m);
    end else begin
      @(negedge clk);
      ce = 1'b0;
      chk("R3 sense phase", ph_now(), 5'b00010);
      chk("R8 rdata held in sense", rdata, last_rd);
      @(negedge clk);
      exp = model[a];
      chk("R3 ready after read", ph_now(), 5'b10000);
      chk("R6 R7 R9 read data", rdata, exp);
      last_rd = exp;
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset phases", ph_now(), 5'b10000);
    chk("R1 reset rdata", rdata, '0);

    for (int k = 0; k < WORDS; k++) begin
      model[k] = '0;
      do_op(1'b1, AW'(k), '1, DATA_W'(32'h1000_0000 + k * 32'h0101_0101), 1'b0);
    end
    // R6: neighbouring columns of one row stay distinct
    do_op(1'b0, AW'(0), '0, '0, 1'b0);
    do_op(1'b0, AW'(1), '0, '0, 1'b0);
    do_op(1'b0, AW'(3), '0, '0, 1'b0);
    do_op(1'b0, AW'(WORDS - 1), '0, '0, 1'b0);
    // R7: partial mask, then zero mask
    do_op(1'b1, AW'(5), 32'hF0F0_00FF, 32'hAAAA_5555, 1'b0);
    do_op(1'b0, AW'(5), '0, '0, 1'b0);
    do_op(1'b1, AW'(6), 32'h0, 32'hFFFF_FFFF, 1'b0);
    do_op(1'b0, AW'(6), '0, '0, 1'b0);
    // R9: requests during busy phases
    do_op(1'b1, AW'(8), '1, 32'hDEAD_BEEF, 1'b1);
    do_op(1'b0, AW'(9), '0, '0, 1'b0);
    do_op(1'b0, AW'(8), '0, '0, 1'b1);
    do_op(1'b0, AW'(9), '0, '0, 1'b0);
    // R8: idle cycles leave rdata alone
    repeat (5) @(negedge clk);
    chk("R8 rdata idle", rdata, last_rd);
    chk("R8 idle phases", ph_now(), 5'b10000);

    for (int k = 0; k < 300; k++) begin
      bit w, p;
      logic [AW-1:0] a;
      w = ($urandom % 2) == 1;
      p = ($urandom % 5) == 0;
      a = AW'($urandom % WORDS);
      do_op(w, a, $urandom, $urandom, p);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    done = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule